// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the front end of a small processor whose program memory is read one byte at a time. It owns the program counter and places it on the memory address lines. It raises a read strobe for each byte it needs and waits for the memory to return that byte. The first byte of every instruction is the opcode. The opcode goes into an instruction register that holds nothing else. The sequencer then spends one cycle working out the instruction length from that opcode. Only the move-immediate opcode has a second byte. For that opcode the sequencer makes a second bus read, and the immediate byte goes into a separate operand register.

When the instruction is complete, the sequencer offers the opcode and operand to the execute stage under a valid/ready handshake. It keeps them unchanged until the execute stage accepts them. Jumps, calls and returns overwrite the program counter through a load request. A load request drops whatever instruction is partly fetched. A synchronous reset returns the counter to a reset vector.

Top module: `ifetch_seq`

## Requirements
- R1: While `mem_rd` is high and `mem_rvalid` is low (with no load or reset), the next cycle still has `mem_rd` high and `prog_addr` unchanged. Each instruction byte costs exactly one accepted read.
- R2: `instr_opcode` holds only the opcode byte. While `instr_valid` is high and not accepted, it stays unchanged.
- R3: For the two-byte opcode `IMM_OP` (default 8'h0E), the issued `instr_operand` equals the byte at the opcode address plus one, and `operand_present` is 1.
- R4: In the cycle after the opcode byte is accepted, `mem_rd` and `instr_valid` are both low (the length decode cycle). A second read is made only when the opcode equals `IMM_OP`.
- R5: `prog_addr` rises by one for each accepted read. When an instruction that started at N is issued, `prog_addr` is N+2 for the two-byte opcode and N+1 otherwise.
- R6: For every opcode other than `IMM_OP`, the issued `instr_operand` is 8'h00 and `operand_present` is 0.
- R7: `instr_valid` stays high until `instr_ready` is seen. In the cycle after acceptance, the sequencer reads the opcode at the current `prog_addr`.
- R8: A `pc_load` has priority over read data and acceptance. In the next cycle, `prog_addr` equals `pc_load_addr`, `mem_rd` is high and `instr_valid` is low, and any partly fetched instruction is dropped.
- R9: One cycle after a synchronous `rst`, `prog_addr` equals `RESET_VEC` (default 16'h2000), `mem_rd` is high and `instr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | AW | Program counter, driven as the memory read address |
| mem_rd | output | 1 | Read strobe, held until data returns |
| mem_rdata | input | 8 | Byte returned by program memory |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| pc_load | input | 1 | Overwrite the program counter (jump, call, return) |
| pc_load_addr | input | AW | New program counter value |
| instr_valid | output | 1 | An instruction is offered to execute |
| instr_ready | input | 1 | Execute stage accepts the instruction |
| instr_opcode | output | 8 | Instruction register (opcode only) |
| instr_operand | output | 8 | Immediate byte, zero for one-byte instructions |
| operand_present | output | 1 | High for the two-byte instruction |

## Verification
A wrong sequencer state or length decode shows at the ports within one or two cycles. It appears as a read strobe in the decode cycle, a read at the wrong address, or a missing operand read. A program counter that steps wrongly shows as a wrong `prog_addr` on the very next read. It also shows when the next opcode is fetched, because a one-byte error moves every later instruction boundary. An instruction register that is overwritten too early shows as `instr_opcode` or `instr_operand` changing while the handshake is stalled. A mishandled load shows as a read at the old address in the cycle after the request.

// File: rtl/ifetch_seq.sv
module ifetch_seq #(
  parameter int              AW        = 16,
  parameter logic [AW-1:0]   RESET_VEC = 'h2000,
  parameter logic [7:0]      IMM_OP    = 8'h0E
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] prog_addr,
  output logic          mem_rd,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_rvalid,
  input  logic          pc_load,
  input  logic [AW-1:0] pc_load_addr,
  output logic          instr_valid,
  input  logic          instr_ready,
  output logic [7:0]    instr_opcode,
  output logic [7:0]    instr_operand,
  output logic          operand_present
);

  typedef enum logic [1:0] {
    S_FOP   = 2'd0,
    S_DEC   = 2'd1,
    S_FOPND = 2'd2,
    S_ISS   = 2'd3
  } st_t;

  st_t           state;
  logic [AW-1:0] pc;
  logic [7:0]    ir;
  logic [7:0]    opnd;
  logic          has_opnd;

  wire take = mem_rd & mem_rvalid;

  assign prog_addr       = pc;
  assign mem_rd          = (state == S_FOP) || (state == S_FOPND);
  assign instr_valid     = (state == S_ISS);
  assign instr_opcode    = ir;
  assign instr_operand   = opnd;
  assign operand_present = has_opnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RESET_VEC;
      state    <= S_FOP;
      ir       <= 8'h00;
      opnd     <= 8'h00;
      has_opnd <= 1'b0;
    end else if (pc_load) begin
      pc    <= pc_load_addr;
      state <= S_FOP;
    end else begin
      case (state)
        S_FOP: if (take) begin
          ir       <= mem_rdata;
          opnd     <= 8'h00;
          has_opnd <= 1'b0;
          pc       <= pc + 1'b1;
          state    <= S_DEC;
        end
        S_DEC: state <= (ir == IMM_OP) ? S_FOPND : S_ISS;
        S_FOPND: if (take) begin
          opnd     <= mem_rdata;
          has_opnd <= 1'b1;
          pc       <= pc + 1'b1;
          state    <= S_ISS;
        end
        default: if (instr_ready) state <= S_FOP;
      endcase
    end
  end

endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] RESET_VEC = 'h2000,
  parameter logic [7:0]    IMM_OP    = 8'h0E
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    st,
  input logic [AW-1:0] prog_addr,
  input logic          mem_rd,
  input logic          mem_rvalid,
  input logic          pc_load,
  input logic [AW-1:0] pc_load_addr,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic [7:0]    instr_opcode,
  input logic [7:0]    instr_operand,
  input logic          operand_present
);

  p_hold_read_r1: assert property (@(posedge clk) disable iff (rst)
    mem_rd && !mem_rvalid && !pc_load |=> mem_rd && $stable(prog_addr));

  p_ir_stable_r2: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !instr_ready && !pc_load |=> $stable(instr_opcode) && $stable(instr_operand)
      && $stable(operand_present));

  p_imm_flag_r3: assert property (@(posedge clk) disable iff (rst)
    instr_valid && operand_present |-> instr_opcode == IMM_OP);

  p_decode_gap_r4: assert property (@(posedge clk) disable iff (rst)
    st == 2'd0 && mem_rd && mem_rvalid && !pc_load |=> !mem_rd && !instr_valid);

  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd && mem_rvalid && !pc_load |=> prog_addr == $past(prog_addr) + 1'b1);

  p_one_byte_zero_r6: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !operand_present |-> instr_operand == 8'h00);

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !instr_ready && !pc_load |=> instr_valid);

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && instr_valid));

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> prog_addr == $past(pc_load_addr) && mem_rd && !instr_valid);

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> prog_addr == RESET_VEC && mem_rd && !instr_valid);

endmodule

bind ifetch_seq ifetch_seq_chk #(.AW(AW), .RESET_VEC(RESET_VEC), .IMM_OP(IMM_OP)) u_chk (
  .clk(clk), .rst(rst), .st(state), .prog_addr(prog_addr), .mem_rd(mem_rd),
  .mem_rvalid(mem_rvalid), .pc_load(pc_load), .pc_load_addr(pc_load_addr),
  .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_opcode(instr_opcode),
  .instr_operand(instr_operand), .operand_present(operand_present)
);

// File: tb/ifetch_seq_tb.sv
`timescale 1ns/1ps
module ifetch_seq_tb;
  localparam int         AW  = 16;
  localparam logic [15:0] RV = 16'h2000;
  localparam logic [7:0] IMM = 8'h0E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] prog_addr;
  logic mem_rd;
  logic [7:0] mem_rdata = 8'h00;
  logic mem_rvalid = 1'b0;
  logic pc_load = 1'b0;
  logic [AW-1:0] pc_load_addr = '0;
  logic instr_valid;
  logic instr_ready = 1'b0;
  logic [7:0] instr_opcode, instr_operand;
  logic operand_present;

  always #2 clk = ~clk;

  ifetch_seq #(.AW(AW), .RESET_VEC(RV), .IMM_OP(IMM)) u_dut (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .pc_load(pc_load), .pc_load_addr(pc_load_addr),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_opcode(instr_opcode),
    .instr_operand(instr_operand), .operand_present(operand_present)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  logic [15:0] pc_ref = RV;
  bit got_op = 0, gap = 0, checked = 0, after_load = 0, after_rst = 0, hold_exp = 0;
  logic [7:0] sv_op, sv_opnd;
  bit sv_pres;
  int wcnt = 0, scnt = 0, cyc = 0;
  logic [15:0] last_addr = '0;
  bit last_rd = 0;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] h;
    h = (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    if (h[1:0] == 2'b00) return IMM;
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input int lat, input int stall, input int load_per, input bit do_rst);
    logic [7:0] eop, eopnd;
    bit two;
    bit rv, rdy, ld;
    @(negedge clk);
    // observe
    if (after_rst) begin
      chk(prog_addr == RV, "R9", "addr after reset", prog_addr, RV);
      chk(mem_rd && !instr_valid, "R9", "rd/valid after reset", {mem_rd, instr_valid}, 2'b10);
      after_rst = 0;
    end
    if (after_load) begin
      chk(mem_rd && !instr_valid && prog_addr == pc_ref, "R8", "fetch at loaded addr",
          {mem_rd, instr_valid, prog_addr}, {2'b10, pc_ref});
      after_load = 0;
    end
    if (gap) begin
      chk(!mem_rd && !instr_valid, "R4", "decode cycle idle", {mem_rd, instr_valid}, 0);
      gap = 0;
    end
    if (hold_exp) chk(instr_valid, "R7", "valid held", instr_valid, 1);
    if (mem_rd) begin
      chk(prog_addr == (got_op ? pc_ref + 16'd1 : pc_ref), "R1", "read address",
          prog_addr, got_op ? pc_ref + 16'd1 : pc_ref);
      if (got_op) chk(mem_byte(pc_ref) == IMM, "R4", "operand read only for imm",
                      mem_byte(pc_ref), IMM);
    end
    if (instr_valid) begin
      eop = mem_byte(pc_ref);
      two = (eop == IMM);
      eopnd = two ? mem_byte(pc_ref + 16'd1) : 8'h00;
      if (!checked) begin
        chk(instr_opcode == eop, "R2", "opcode", instr_opcode, eop);
        if (two) chk(instr_operand == eopnd && operand_present, "R3", "imm operand",
                     {operand_present, instr_operand}, {1'b1, eopnd});
        else     chk(instr_operand == 8'h00 && !operand_present, "R6", "no operand",
                     {operand_present, instr_operand}, 0);
        chk(prog_addr == pc_ref + (two ? 16'd2 : 16'd1), "R5", "pc at issue",
            prog_addr, pc_ref + (two ? 16'd2 : 16'd1));
        sv_op = instr_opcode; sv_opnd = instr_operand; sv_pres = operand_present;
        checked = 1;
      end else begin
        chk(instr_opcode == sv_op && instr_operand == sv_opnd && operand_present == sv_pres,
            "R2", "stalled outputs stable", {instr_opcode, instr_operand}, {sv_op, sv_opnd});
      end
    end
    // drive
    if (mem_rd && last_rd && prog_addr == last_addr) wcnt++; else wcnt = 0;
    last_rd = mem_rd; last_addr = prog_addr;
    rv = mem_rd && (wcnt >= lat);
    if (instr_valid) begin rdy = (scnt >= stall); scnt++; end
    else begin rdy = cyc[0]; scnt = 0; end
    ld = (load_per != 0) && (cyc % load_per == load_per - 1) && !do_rst;
    mem_rvalid = rv;
    mem_rdata = mem_byte(prog_addr);
    instr_ready = rdy;
    pc_load = ld;
    pc_load_addr = RV + 16'(cyc * 37);
    rst = do_rst;
    cyc++;
    // model
    hold_exp = instr_valid && !rdy && !ld && !do_rst;
    if (do_rst) begin
      pc_ref = RV; got_op = 0; checked = 0; gap = 0; after_rst = 1; hold_exp = 0;
    end else if (ld) begin
      pc_ref = pc_load_addr; got_op = 0; checked = 0; gap = 0; after_load = 1;
    end else if (rv) begin
      if (!got_op) begin got_op = 1; gap = 1; end
    end else if (instr_valid && rdy) begin
      pc_ref = pc_ref + ((mem_byte(pc_ref) == IMM) ? 16'd2 : 16'd1);
      got_op = 0; checked = 0;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R7 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cycle(0, 0, 0, 1'b1);
    for (int pass = 0; pass < 2; pass++)
      for (int lat = 0; lat < 3; lat++)
        for (int st = 0; st < 3; st++)
          for (int k = 0; k < 300; k++)
            cycle(lat, st, pass ? 11 + lat + st : 0, (pass == 1) && (k == 150));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule